// File: doc/BRIEF.md
# Leaky-Bucket Lock Detector

This block judges whether a digital PLL has settled. Each cycle it may receive one signed error sample. The sample is either a phase error in picoseconds or, in the frequency-lock use, the absolute difference between the reference period and the feedback period. The block compares the sample's magnitude with a programmable threshold. A sample inside the window adds a programmable fill amount to an internal signed level. A sample outside the window subtracts a programmable drain amount. The polarity of the error never affects this choice.

The lock flag follows the level with hysteresis. It sets once the level climbs above +1024, clears once the level sinks below -1024, and otherwise keeps its value. The level saturates at ±2047, so it cannot wrap. Two mode inputs override normal operation:

- **Free-run/holdover.** The flag reads unlocked, and the level and flag return to neutral.
- **Reference switchover.** Everything freezes and incoming samples are dropped.

The threshold width is a parameter. A 16-bit threshold suits phase lock and a 24-bit threshold suits frequency lock.

Top module: `lock_judge`

## Requirements
- R1: After reset the level is zero and lockFlag is 0.
- R2: A valid sample whose absolute value is less than or equal to threshold adds fillAmt to the level, whatever the sign of the sample.
- R3: A valid sample whose absolute value exceeds threshold subtracts drainAmt from the level.
- R4: Each valid sample causes exactly one fill or one drain. With sampleValid low, errSample is ignored and the level does not change.
- R5: lockFlag becomes 1 once the level is strictly above +1024. A level of exactly +1024 does not set it.
- R6: lockFlag becomes 0 once the level is strictly below -1024. A level of exactly -1024 does not clear it.
- R7: While the level lies between -1024 and +1024 inclusive, lockFlag keeps its previous value.
- R8: The level saturates at +2047 and -2047 and never wraps.
- R9: A fillAmt or drainAmt of zero leaves the level unchanged for that decision.
- R10: While holdoverMode is 1, lockFlag reads 0 and samples are ignored. The level returns to zero and the internal flag to unlocked on the next clock edge.
- R11: While switchActive is 1 and holdoverMode is 0, the level and the lock flag hold their values and samples are ignored.
- R12: When holdoverMode and switchActive are both 1, the holdover behaviour of R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking errSample as a new sample |
| errSample | input | ERR_W (24) | Signed two's-complement error sample in picoseconds |
| threshold | input | THR_W (16) | Unsigned window half-width in picoseconds |
| fillAmt | input | AMT_W (8) | Unsigned amount added for an in-window sample |
| drainAmt | input | AMT_W (8) | Unsigned amount subtracted for an out-of-window sample |
| holdoverMode | input | 1 | Free-run or holdover active: force unlock and clear level |
| switchActive | input | 1 | Reference switchover in progress: freeze state |
| lockFlag | output | 1 | 1 when locked |

## Verification
The bench builds the block with its defaults: a 24-bit error, a 16-bit threshold, 8-bit amounts, marks at ±1024 and saturation at ±2047. With amounts of 128 and 255, the marks and the saturation bound are crossed in 8 to 20 samples. The level is hidden, so the bench infers it from the exact sample count at which the flag changes. For example, eight fills of 128 land on exactly +1024 and must not lock, while a ninth must lock. Recovery counts after saturation, after a switchover freeze and after holdover each differ from the counts that a wrapping, drifting or uncleared level would give.

// File: rtl/lock_judge_pkg.sv
package lock_judge_pkg;

  // Strobes from control to datapath; at most one is high in any cycle.
  typedef struct packed {
    logic clearAll;  // return level and flag to neutral
    logic freeze;    // hold level and flag
    logic doFill;    // add fill amount
    logic doDrain;   // subtract drain amount
  } lvlCmd_t;

endpackage

// File: rtl/lock_judge_mag.sv
module lock_judge_mag #(
  parameter int ERR_W = 24,
  parameter int THR_W = 16
) (
  input  logic signed [ERR_W-1:0] errSample,
  input  logic        [THR_W-1:0] threshold,
  output logic                    inWindow
);

  localparam int CMP_W = (ERR_W > THR_W) ? ERR_W : THR_W;

  logic [ERR_W-1:0] magU;
  logic [CMP_W-1:0] magWide;
  logic [CMP_W-1:0] thrWide;

  // Two's-complement magnitude; the most negative code maps to 2^(ERR_W-1).
  always_comb begin
    if (errSample[ERR_W-1]) magU = ~errSample + ERR_W'(1);
    else                    magU = errSample;
  end

  assign magWide  = CMP_W'(magU);
  assign thrWide  = CMP_W'(threshold);
  assign inWindow = (magWide <= thrWide);

endmodule

// File: rtl/lock_judge_ctl.sv
module lock_judge_ctl
  import lock_judge_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int THR_W = 16
) (
  input  logic                    sampleValid,
  input  logic signed [ERR_W-1:0] errSample,
  input  logic        [THR_W-1:0] threshold,
  input  logic                    holdoverMode,
  input  logic                    switchActive,
  output lvlCmd_t                 cmd
);

  logic inWindow;
  logic normalOp;

  lock_judge_mag #(.ERR_W(ERR_W), .THR_W(THR_W)) i_mag (
    .errSample (errSample),
    .threshold (threshold),
    .inWindow  (inWindow)
  );

  // Holdover outranks switchover; samples act only in normal operation.
  assign normalOp = !holdoverMode && !switchActive;

  always_comb begin
    cmd.clearAll = holdoverMode;
    cmd.freeze   = switchActive && !holdoverMode;
    cmd.doFill   = normalOp && sampleValid && inWindow;
    cmd.doDrain  = normalOp && sampleValid && !inWindow;
  end

endmodule

// File: rtl/lock_judge_dp.sv
module lock_judge_dp
  import lock_judge_pkg::*;
#(
  parameter int AMT_W     = 8,
  parameter int SAT_BOUND = 2047,
  parameter int HIGH_MARK = 1024,
  parameter int LOW_MARK  = -1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvlCmd_t          cmd,
  input  logic [AMT_W-1:0] fillAmt,
  input  logic [AMT_W-1:0] drainAmt,
  output logic             lockQ
);

  localparam int LVL_W = $clog2(SAT_BOUND + 1) + 1;
  localparam int SUM_W = ((LVL_W > AMT_W) ? LVL_W : AMT_W) + 2;

  localparam logic signed [SUM_W-1:0] SAT_HI  = SUM_W'(SAT_BOUND);
  localparam logic signed [SUM_W-1:0] SAT_LO  = -SUM_W'(SAT_BOUND);
  localparam logic signed [SUM_W-1:0] HI_W    = SUM_W'(HIGH_MARK);
  localparam logic signed [SUM_W-1:0] LO_W    = SUM_W'(LOW_MARK);
  localparam logic signed [LVL_W-1:0] SAT_L   = LVL_W'(SAT_BOUND);
  localparam logic signed [LVL_W-1:0] HI_L    = LVL_W'(HIGH_MARK);
  localparam logic signed [LVL_W-1:0] LO_L    = LVL_W'(LOW_MARK);

  logic signed [LVL_W-1:0] level;
  logic signed [LVL_W-1:0] levelNext;
  logic signed [SUM_W-1:0] levelWide;
  logic signed [SUM_W-1:0] fillWide;
  logic signed [SUM_W-1:0] drainWide;
  logic signed [SUM_W-1:0] stepped;
  logic signed [SUM_W-1:0] satWide;
  logic                    lockNext;

  assign levelWide = SUM_W'(level);
  assign fillWide  = SUM_W'(fillAmt);
  assign drainWide = SUM_W'(drainAmt);

  always_comb begin
    if (cmd.doFill)       stepped = levelWide + fillWide;
    else if (cmd.doDrain) stepped = levelWide - drainWide;
    else                  stepped = levelWide;

    if (stepped > SAT_HI)      satWide = SAT_HI;
    else if (stepped < SAT_LO) satWide = SAT_LO;
    else                       satWide = stepped;
    levelNext = LVL_W'(satWide);

    // Hysteresis: only a strict crossing of a mark moves the flag.
    if (satWide > HI_W)      lockNext = 1'b1;
    else if (satWide < LO_W) lockNext = 1'b0;
    else                     lockNext = lockQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clearAll) begin
      level <= '0;
      lockQ <= 1'b0;
    end else if (!cmd.freeze) begin
      level <= levelNext;
      lockQ <= lockNext;
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level <= SAT_L) && (level >= -SAT_L));

  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clearAll, cmd.freeze, cmd.doFill, cmd.doDrain}));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.clearAll || cmd.freeze || cmd.doFill || cmd.doDrain)
      |=> $stable(level) && $stable(lockQ));

  // R2
  fill_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.doFill && fillAmt != '0 && level < SAT_L) |=> (level > $past(level)));

  // R3
  drain_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.doDrain && drainAmt != '0 && level > -SAT_L) |=> (level < $past(level)));

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> (level > HI_L));

  // R6
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> ((level < LO_L) || $past(cmd.clearAll)));

  // R10
  holdover_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (level == '0) && !lockQ);

  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.freeze |=> $stable(level) && $stable(lockQ));

endmodule

// File: rtl/lock_judge.sv
module lock_judge
  import lock_judge_pkg::*;
#(
  parameter int ERR_W     = 24,
  parameter int THR_W     = 16,
  parameter int AMT_W     = 8,
  parameter int SAT_BOUND = 2047,
  parameter int HIGH_MARK = 1024,
  parameter int LOW_MARK  = -1024
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic signed [ERR_W-1:0] errSample,
  input  logic        [THR_W-1:0] threshold,
  input  logic        [AMT_W-1:0] fillAmt,
  input  logic        [AMT_W-1:0] drainAmt,
  input  logic                    holdoverMode,
  input  logic                    switchActive,
  output logic                    lockFlag
);

  lvlCmd_t cmd;
  logic    lockQ;

  lock_judge_ctl #(.ERR_W(ERR_W), .THR_W(THR_W)) i_ctl (
    .sampleValid  (sampleValid),
    .errSample    (errSample),
    .threshold    (threshold),
    .holdoverMode (holdoverMode),
    .switchActive (switchActive),
    .cmd          (cmd)
  );

  lock_judge_dp #(
    .AMT_W     (AMT_W),
    .SAT_BOUND (SAT_BOUND),
    .HIGH_MARK (HIGH_MARK),
    .LOW_MARK  (LOW_MARK)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .fillAmt  (fillAmt),
    .drainAmt (drainAmt),
    .lockQ    (lockQ)
  );

  // Free-run/holdover reads unlocked in the same cycle it is raised.
  assign lockFlag = lockQ && !holdoverMode;

  // R10
  holdover_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdoverMode) |-> !lockQ);

endmodule

// File: tb/test_lock_judge.sv
module test_lock_judge;

  logic               clk = 1'b0;
  logic               rstN;
  logic               sampleValid;
  logic signed [23:0] errSample;
  logic        [15:0] threshold;
  logic        [7:0]  fillAmt;
  logic        [7:0]  drainAmt;
  logic               holdoverMode;
  logic               switchActive;
  logic               lockFlag;

  int nRun  = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  lock_judge i_lock_judge (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .errSample    (errSample),
    .threshold    (threshold),
    .fillAmt      (fillAmt),
    .drainAmt     (drainAmt),
    .holdoverMode (holdoverMode),
    .switchActive (switchActive),
    .lockFlag     (lockFlag)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: lockFlag=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; errSample = '0;
    holdoverMode = 1'b0; switchActive = 1'b0;
    threshold = 16'd100; fillAmt = 8'd128; drainAmt = 8'd128;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // n consecutive valid samples; returns on the negedge after the last capture.
  task automatic feed(input logic signed [23:0] e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      errSample = e;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic tResetBoundary();
    doReset();
    chk("R1", "after reset", lockFlag, 1'b0);
    feed(24'sd50, 8);
    chk("R5", "level exactly +1024", lockFlag, 1'b0);
    feed(24'sd50, 1);
    chk("R5", "level +1152", lockFlag, 1'b1);
  endtask

  task automatic tSignEdge();
    doReset();
    feed(-24'sd100, 8);
    chk("R2", "negative edge samples x8", lockFlag, 1'b0);
    feed(-24'sd100, 1);
    chk("R2", "|e|==thr fills, sign ignored", lockFlag, 1'b1);
  endtask

  task automatic tHysteresis();
    doReset();
    feed(24'sd100, 9);
    feed(-24'sd101, 17);
    chk("R7", "drained to -1024, still locked", lockFlag, 1'b1);
    feed(24'sd101, 1);
    chk("R3", "positive out-of-window drains to -1152", lockFlag, 1'b0);
    feed(24'sd0, 17);
    chk("R7", "filled to +1024, still unlocked", lockFlag, 1'b0);
    feed(24'sd0, 1);
    chk("R6", "refill to +1152 relocks after clear", lockFlag, 1'b1);
  endtask

  task automatic tNoValid();
    doReset();
    feed(24'sd10, 8);
    errSample = 24'sh7FFFFF;
    repeat (20) @(negedge clk);
    chk("R4", "no strobe, still at +1024", lockFlag, 1'b0);
    feed(24'sd10, 1);
    chk("R4", "one more sample locks: idle cycles changed nothing", lockFlag, 1'b1);
  endtask

  task automatic tSaturation();
    doReset();
    fillAmt = 8'd255; drainAmt = 8'd255;
    feed(24'sd1, 20);
    feed(24'sd500, 12);
    chk("R8", "12 drains from +2047 give -1013", lockFlag, 1'b1);
    feed(24'sd500, 1);
    chk("R8", "13th drain gives -1268", lockFlag, 1'b0);
    feed(-24'sd500, 20);
    feed(24'sd1, 12);
    chk("R8", "12 fills from -2047 give +1013", lockFlag, 1'b0);
    feed(24'sd1, 1);
    chk("R8", "13th fill gives +1268", lockFlag, 1'b1);
  endtask

  task automatic tZeroAmt();
    doReset();
    fillAmt = 8'd0;
    feed(24'sd5, 30);
    chk("R9", "zero fill never locks", lockFlag, 1'b0);
    fillAmt = 8'd128;
    feed(24'sd5, 9);
    chk("R9", "level still 0 after zero fills", lockFlag, 1'b1);
    drainAmt = 8'd0;
    feed(24'sd999, 30);
    drainAmt = 8'd128;
    feed(24'sd999, 17);
    chk("R9", "zero drains left +1152", lockFlag, 1'b1);
    feed(24'sd999, 1);
    chk("R9", "18th real drain unlocks", lockFlag, 1'b0);
  endtask

  task automatic tHoldover();
    doReset();
    feed(24'sd5, 9);
    @(negedge clk);
    holdoverMode = 1'b1;
    #1 chk("R10", "flag reads unlocked at once", lockFlag, 1'b0);
    sampleValid = 1'b1; errSample = 24'sd5;
    repeat (5) @(negedge clk);
    chk("R10", "unlocked throughout holdover", lockFlag, 1'b0);
    sampleValid = 1'b0; holdoverMode = 1'b0;
    feed(24'sd5, 8);
    chk("R10", "level restarted from 0", lockFlag, 1'b0);
    feed(24'sd5, 1);
    chk("R10", "relock after 9 fills", lockFlag, 1'b1);
  endtask

  task automatic tSwitch();
    doReset();
    feed(24'sd5, 9);
    @(negedge clk);
    switchActive = 1'b1;
    feed(24'sd999, 30);
    chk("R11", "locked held during switchover", lockFlag, 1'b1);
    switchActive = 1'b0;
    feed(24'sd999, 17);
    chk("R11", "level frozen at +1152", lockFlag, 1'b1);
    feed(24'sd999, 1);
    chk("R11", "18th drain unlocks", lockFlag, 1'b0);
    switchActive = 1'b1;
    feed(24'sd5, 30);
    chk("R11", "unlocked held during switchover", lockFlag, 1'b0);
    switchActive = 1'b0;
    feed(24'sd5, 17);
    chk("R11", "level frozen at -1152", lockFlag, 1'b0);
    feed(24'sd5, 1);
    chk("R11", "18th fill locks", lockFlag, 1'b1);
  endtask

  task automatic tBoth();
    doReset();
    feed(24'sd5, 9);
    @(negedge clk);
    holdoverMode = 1'b1; switchActive = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "holdover wins over switchover", lockFlag, 1'b0);
    holdoverMode = 1'b0; switchActive = 1'b0;
    feed(24'sd5, 8);
    chk("R12", "level cleared, 8 fills unlocked", lockFlag, 1'b0);
    feed(24'sd5, 1);
    chk("R12", "9th fill locks", lockFlag, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    tResetBoundary();
    tSignEdge();
    tHysteresis();
    tNoValid();
    tSaturation();
    tZeroAmt();
    tHoldover();
    tSwitch();
    tBoth();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule